// File: doc/BRIEF.md
# NAND one-bit ECC parity generator

This block builds a Hamming-style parity code over NAND page data as the data crosses the external memory bus. It keeps four independent accumulators, one for each chip select. Each data beat arrives with the index of the chip select it belongs to. The beat is folded into that chip select's accumulator only while the accumulator is running. Software starts an accumulator by writing a one to its start bit. Software later reads the finished parity word, and that read stops the accumulator. Software then compares this word with the code stored in the spare area and does any error location itself.

The code is defined over a bit address formed from the beat's position in the page and the bit's position inside the beat. Every code term k has two parts. The odd part is the XOR of all data bits whose address has bit k set. The even part is the XOR of all data bits whose address has bit k clear. The low terms are column parities inside a beat, and the higher terms are row parities over beat positions. Where that split falls depends on whether the device is 8 or 16 bits wide.

Each accumulator is a two-state machine. `LANE_IDLE` goes to `LANE_ACCUM` on a start write. `LANE_ACCUM` returns to `LANE_IDLE` when its parity word is read. `LANE_ACCUM` restarts in place, staying in `LANE_ACCUM`, on a new start write. `LANE_IDLE` holds when there is no start write, and `LANE_ACCUM` holds when there is neither a start write nor a read.

Top module: `nand_ecc1_gen`

## Requirements
- R1: After reset, `running` is 0000 and `rd_data` is 0. Reading any chip select before it has been started returns 0.
- R2: A 1 in bit n of `start_mask` sets `running[n]` on the next clock edge. The same edge clears chip select n's parity word and its beat index. A 0 bit has no effect on that chip select.
- R3: When `rd_en` is high, `rd_data` shows the parity word of chip select `rd_cs` after the next edge. That edge also clears `running[rd_cs]`. `rd_data` holds its value while `rd_en` is low.
- R4: A beat changes only the accumulator named by `beat_cs`, and only while that accumulator is running. Beats for idle or other chip selects leave the parity word unchanged.
- R5: With `wide`=0 (8-bit device), only `beat_data[7:0]` is used. The bit address is {beat index[8:0], bit[2:0]}, so terms 0..2 are column parities and terms 3..11 are row parities. The odd part of term k is the XOR of the bits whose address bit k is 1. The even part is the XOR of the bits whose address bit k is 0.
- R6: With `wide`=1 (16-bit device), `beat_data[15:0]` is used. The bit address is {beat index[7:0], bit[3:0]}, so terms 0..3 are column parities and terms 4..11 are row parities. The odd and even parts are defined as in R5.
- R7: In the parity word, bit 16+k holds the odd part of term k and bit k holds the even part of term k, for k = 0..11. The highest odd row parity is therefore at bit 27. Bits 31:28 and 15:12 read 0.
- R8: The beat index starts at 0 on a start write. It counts the accumulated beats and wraps to 0 after 512 beats in 8-bit mode and after 256 beats in 16-bit mode.
- R9: If a start write and a read hit the same chip select in one cycle, the start wins. `running` stays 1, the parity word is cleared, and `rd_data` returns the value from before the clear. A beat in the same cycle as a start or a read of its chip select is not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| start_mask | input | 4 | Start write, one bit per chip select |
| beat_valid | input | 1 | A data beat is present this cycle |
| beat_cs | input | 2 | Chip select of the beat |
| beat_data | input | 16 | Beat data (bits 7:0 only in 8-bit mode) |
| rd_en | input | 1 | Parity word read strobe |
| rd_cs | input | 2 | Chip select to read |
| rd_data | output | 32 | Last parity word read |
| running | output | 4 | Start bits, one per chip select |

## Verification
A start write or a beat applied before a clock edge takes effect at that edge. The new `running` value can be seen one cycle after the start write. A beat's contribution shows up in `rd_data` only through a later read. A read returns its word in `rd_data`, and clears the `running` bit, one cycle after `rd_en`. The bench drives every input on the falling edge and samples at the next falling edge, so each result is sampled exactly one register stage later. The expected words come from a bench model that stores the raw beats for each chip select and then evaluates each code term over the R5 and R6 bit addresses.

// File: rtl/nand_ecc1_pkg.sv
package nand_ecc1_pkg;
    localparam int unsigned TERMS  = 12;   // code terms (odd and even part each)
    localparam int unsigned IDX_W  = 9;    // beat index width in 8-bit mode
    localparam int unsigned DATA_W = 16;   // widest beat
    localparam int unsigned HALF_W = 16;   // half of the parity word

    typedef enum logic {
        LANE_IDLE  = 1'b0,
        LANE_ACCUM = 1'b1
    } lane_state_e;
endpackage

// File: rtl/ecc1_beat_terms.sv
module ecc1_beat_terms
    import nand_ecc1_pkg::*;
#(
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_IDX_W  = IDX_W,
    parameter int unsigned P_TERMS  = TERMS
) (
    input  logic [P_DATA_W-1:0] data,
    input  logic [P_IDX_W-1:0]  idx,
    input  logic                wide,
    output logic [P_TERMS-1:0]  odd,
    output logic [P_TERMS-1:0]  even
);
    localparam int unsigned NB = P_TERMS - P_IDX_W;               // bit-position width, narrow
    localparam logic [P_TERMS-1:0] WIDE_MASK = P_TERMS'((1 << (P_IDX_W - 1)) - 1);

    logic [P_TERMS-1:0] idx_ext;
    assign idx_ext = P_TERMS'(idx);

    always_comb begin
        odd  = '0;
        even = '0;
        for (int j = 0; j < int'(P_DATA_W); j++) begin
            logic [P_TERMS-1:0] addr;
            if (wide) begin
                addr = ((idx_ext & WIDE_MASK) << (NB + 1)) | P_TERMS'(j);
            end else begin
                addr = (idx_ext << NB) | P_TERMS'(j);
            end
            if (wide || (j < int'(P_DATA_W / 2))) begin
                for (int k = 0; k < int'(P_TERMS); k++) begin
                    if (addr[k]) begin
                        odd[k]  = odd[k] ^ data[j];
                    end else begin
                        even[k] = even[k] ^ data[j];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ecc1_lane.sv
module ecc1_lane
    import nand_ecc1_pkg::*;
#(
    parameter int unsigned P_DATA_W = DATA_W,
    parameter int unsigned P_IDX_W  = IDX_W,
    parameter int unsigned P_TERMS  = TERMS,
    parameter int unsigned P_HALF_W = HALF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wide,
    input  logic                  start,
    input  logic                  rd,
    input  logic                  beat,
    input  logic [P_DATA_W-1:0]   data,
    output logic                  running,
    output logic [2*P_HALF_W-1:0] code
);
    localparam int unsigned PAD = P_HALF_W - P_TERMS;

    lane_state_e        state_q, state_d;
    logic [P_TERMS-1:0] odd_q, even_q, odd_b, even_b;
    logic [P_IDX_W-1:0] idx_q, idx_nx;
    logic               take;

    ecc1_beat_terms #(
        .P_DATA_W(P_DATA_W),
        .P_IDX_W (P_IDX_W),
        .P_TERMS (P_TERMS)
    ) u_terms (
        .data(data),
        .idx (idx_q),
        .wide(wide),
        .odd (odd_b),
        .even(even_b)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_IDLE:  if (start) state_d = LANE_ACCUM;
            LANE_ACCUM: begin
                if (start)   state_d = LANE_ACCUM;
                else if (rd) state_d = LANE_IDLE;
            end
            default:    state_d = LANE_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        running = (state_q == LANE_ACCUM);
        code    = {{PAD{1'b0}}, odd_q, {PAD{1'b0}}, even_q};
    end

    assign take   = (state_q == LANE_ACCUM) && beat && !rd && !start;
    assign idx_nx = wide ? {1'b0, idx_q[P_IDX_W-2:0] + (P_IDX_W-1)'(1)}
                         : idx_q + P_IDX_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q  <= '0;
            even_q <= '0;
            idx_q  <= '0;
        end else if (start) begin
            odd_q  <= '0;
            even_q <= '0;
            idx_q  <= '0;
        end else if (take) begin
            odd_q  <= odd_q ^ odd_b;
            even_q <= even_q ^ even_b;
            idx_q  <= idx_nx;
        end
    end
endmodule

// File: rtl/nand_ecc1_gen.sv
module nand_ecc1_gen
    import nand_ecc1_pkg::*;
#(
    parameter int unsigned NCS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wide,
    input  logic [NCS-1:0]         start_mask,
    input  logic                   beat_valid,
    input  logic [$clog2(NCS)-1:0] beat_cs,
    input  logic [DATA_W-1:0]      beat_data,
    input  logic                   rd_en,
    input  logic [$clog2(NCS)-1:0] rd_cs,
    output logic [2*HALF_W-1:0]    rd_data,
    output logic [NCS-1:0]         running
);
    localparam int unsigned CS_W = $clog2(NCS);

    logic [2*HALF_W-1:0] lane_code [NCS];

    for (genvar g = 0; g < int'(NCS); g++) begin : g_lane
        ecc1_lane u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .wide   (wide),
            .start  (start_mask[g]),
            .rd     (rd_en && (rd_cs == CS_W'(g))),
            .beat   (beat_valid && (beat_cs == CS_W'(g))),
            .data   (beat_data),
            .running(running[g]),
            .code   (lane_code[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= lane_code[rd_cs];
    end
endmodule

module ecc1_chk #(
    parameter int unsigned NCS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCS-1:0]         start_mask,
    input logic                   rd_en,
    input logic [$clog2(NCS)-1:0] rd_cs,
    input logic [31:0]            rd_data,
    input logic [NCS-1:0]         running
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (running == '0 && rd_data == '0);
        end
    end

    a_r2_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (start_mask != '0) |=> ((running & $past(start_mask)) == $past(start_mask)));

    a_r2_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((running & ~$past(running) & ~$past(start_mask)) == '0));

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !start_mask[rd_cs]) |=> !running[$past(rd_cs)]);

    a_r3_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    a_r7_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:28] == 4'h0) && (rd_data[15:12] == 4'h0));
endmodule

bind nand_ecc1_gen ecc1_chk #(.NCS(NCS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_mask(start_mask),
    .rd_en     (rd_en),
    .rd_cs     (rd_cs),
    .rd_data   (rd_data),
    .running   (running)
);

// File: tb/test_nand_ecc1_gen.sv
`timescale 1ns/1ps
module test_nand_ecc1_gen;
    localparam int MAXB = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide = 1'b0;
    logic [3:0]  start_mask = '0;
    logic        beat_valid = 1'b0;
    logic [1:0]  beat_cs = '0;
    logic [15:0] beat_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_cs = '0;
    logic [31:0] rd_data;
    logic [3:0]  running;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] beats [4][MAXB];
    int          cnt [4];
    bit          mode [4];
    logic [3:0]  run_exp = '0;

    always #10 clk = ~clk;

    nand_ecc1_gen i_nand_ecc1_gen (
        .clk(clk), .rst_n(rst_n), .wide(wide), .start_mask(start_mask),
        .beat_valid(beat_valid), .beat_cs(beat_cs), .beat_data(beat_data),
        .rd_en(rd_en), .rd_cs(rd_cs), .rd_data(rd_data), .running(running)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected word from stored beats, term by term
    function automatic logic [31:0] expect_word(input int cs);
        logic [11:0] od = '0;
        logic [11:0] ev = '0;
        int w = mode[cs] ? 16 : 8;
        for (int k = 0; k < 12; k++) begin
            for (int n = 0; n < cnt[cs]; n++) begin
                int pos = mode[cs] ? (n % 256) : (n % 512);
                for (int j = 0; j < w; j++) begin
                    int a = pos * w + j;
                    if (((a >> k) & 1) == 1) od[k] = od[k] ^ beats[cs][n][j];
                    else                     ev[k] = ev[k] ^ beats[cs][n][j];
                end
            end
        end
        return {4'h0, od, 4'h0, ev};
    endfunction

    task automatic do_start(input logic [3:0] m);
        start_mask = m;
        for (int c = 0; c < 4; c++) if (m[c]) begin
            cnt[c] = 0; mode[c] = wide; run_exp[c] = 1'b1;
        end
        @(negedge clk);
        start_mask = '0;
    endtask

    task automatic do_beat(input int cs, input logic [15:0] d);
        beat_valid = 1'b1; beat_cs = 2'(cs); beat_data = d;
        if (run_exp[cs] && cnt[cs] < MAXB) begin
            beats[cs][cnt[cs]] = d;
            cnt[cs]++;
        end
        @(negedge clk);
        beat_valid = 1'b0;
    endtask

    task automatic do_read(input string req, input int cs);
        logic [31:0] e;
        e = expect_word(cs);
        rd_en = 1'b1; rd_cs = 2'(cs);
        run_exp[cs] = 1'b0;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rd_data, e);
        chk({req, " running"}, {28'h0, running}, {28'h0, run_exp});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin cnt[c] = 0; mode[c] = 1'b0; end
        repeat (3) @(negedge clk);
        chk("R1 running", {28'h0, running}, 32'h0);
        chk("R1 rd_data", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read("R1 unstarted read", 2);

        // directed: single bit at address 0, 8-bit
        do_start(4'b0001);
        chk("R2 start", {28'h0, running}, 32'h1);
        do_beat(0, 16'h0001);
        do_read("R5 R7 addr0", 0);
        chk("R7 addr0 literal", rd_data, 32'h0000_0FFF);

        // directed: highest row bit, 8-bit, byte 256 bit 0
        do_start(4'b0010);
        for (int n = 0; n < 256; n++) do_beat(1, 16'h0000);
        do_beat(1, 16'h0001);
        do_read("R7 top row 8b", 1);
        chk("R7 bit27 literal", rd_data, 32'h0800_07FF);

        // start with zero bit has no effect; beats to idle lane ignored
        do_start(4'b0100);
        do_beat(2, 16'h00A5);
        do_start(4'b0000);
        chk("R2 zero no effect", {28'h0, running}, 32'h4);
        do_beat(3, 16'h00FF);
        do_read("R4 idle lane 3", 3);
        do_read("R2 R4 lane 2", 2);
        do_beat(2, 16'h0033);
        do_read("R4 frozen after read", 2);

        // random interleaved, 8-bit
        do_start(4'b1111);
        for (int i = 0; i < 400; i++) begin
            int c = int'($urandom_range(0, 3));
            if ($urandom_range(0, 4) == 0) @(negedge clk);
            else do_beat(c, 16'($urandom));
        end
        for (int c = 0; c < 4; c++) do_read("R4 R5 random 8b", c);

        // wrap in 8-bit mode
        do_start(4'b0010);
        for (int i = 0; i < 530; i++) do_beat(1, 16'($urandom));
        do_read("R8 wrap 8b", 1);

        // 16-bit mode
        wide = 1'b1;
        @(negedge clk);
        do_start(4'b0001);
        for (int n = 0; n < 128; n++) do_beat(0, 16'h0000);
        do_beat(0, 16'h0001);
        do_read("R6 top row 16b", 0);
        chk("R6 R7 bit27 literal", rd_data, 32'h0800_07FF);

        do_start(4'b1111);
        for (int i = 0; i < 400; i++) do_beat(int'($urandom_range(0, 3)), 16'($urandom));
        for (int c = 0; c < 4; c++) do_read("R6 random 16b", c);

        do_start(4'b1000);
        for (int i = 0; i < 270; i++) do_beat(3, 16'($urandom));
        do_read("R8 wrap 16b", 3);

        // start and read together: start wins
        do_start(4'b0100);
        for (int i = 0; i < 20; i++) do_beat(2, 16'($urandom));
        begin
            logic [31:0] e;
            e = expect_word(2);
            start_mask = 4'b0100; rd_en = 1'b1; rd_cs = 2'd2;
            cnt[2] = 0; mode[2] = wide; run_exp[2] = 1'b1;
            @(negedge clk);
            start_mask = '0; rd_en = 1'b0;
            chk("R9 start+read data", rd_data, e);
            chk("R9 start+read running", {28'h0, running}, {28'h0, run_exp});
        end
        do_read("R9 cleared by start", 2);

        // beat in same cycle as read: not accumulated
        do_start(4'b0001);
        for (int i = 0; i < 10; i++) do_beat(0, 16'($urandom));
        begin
            logic [31:0] e;
            e = expect_word(0);
            rd_en = 1'b1; rd_cs = 2'd0; beat_valid = 1'b1; beat_cs = 2'd0; beat_data = 16'hBEEF;
            run_exp[0] = 1'b0;
            @(negedge clk);
            rd_en = 1'b0; beat_valid = 1'b0;
            chk("R9 read+beat data", rd_data, e);
        end
        do_read("R9 beat with read ignored", 0);

        // beat in same cycle as start: not accumulated
        begin
            start_mask = 4'b0001; beat_valid = 1'b1; beat_cs = 2'd0; beat_data = 16'hFFFF;
            cnt[0] = 0; mode[0] = wide; run_exp[0] = 1'b1;
            @(negedge clk);
            start_mask = '0; beat_valid = 1'b0;
        end
        do_read("R9 beat with start ignored", 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule